// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block converts single internal read and write requests into bus cycles on a shared 16-bit address/data bus that carries the address and the data on the same wires at different times. An external transparent latch captures the address while the address strobe is high. One of four active-low chip selects marks the target device. Active-low read and write strobes and two active-low byte-lane enables complete the cycle. An extra high-order address pin widens the reachable range beyond 16 bits.

Each chip select has its own 6-bit timing word on the `cs_cfg` input. Slot `n` sits at bits `[6n+5:6n]`. Bits `[2:0]` give the number of extra address cycles (0 to 7). Bit 3 adds an address-hold cycle after the address strobe falls. Bit 4 adds a turnaround cycle after a read. Bit 5 adds a write-hold cycle after the write strobe. The timing word of the selected chip select is captured when a request is accepted.

On the internal side, the requester raises `req_valid` and holds it, with all request fields steady, until `req_ack` pulses. Nothing is driven onto the bus while the global enable `bus_en` is low.

Top module: `xbus_ctrl`

## Requirements
- R1: While `bus_en` is low, a pending request causes no chip-select activity and no acknowledge. Once `bus_en` goes high, the request is executed normally.
- R2: The address phase lasts 1 + W cycles, where W is the wait field (bits [2:0] of the selected slot). During this phase `bus_ale` is high, the bus is driven with address bits [15:0], `bus_a_hi` carries address bit 16, and both strobes are high.
- R3: When the address-hold bit (bit 3) is set, exactly one cycle follows the address phase with `bus_ale` low, the address still driven and both strobes high. When the bit is clear, there is no such cycle.
- R4: The read or write strobe is low for exactly one cycle. During a read strobe the bus is not driven (`bus_ad_oe` low). During a write strobe the write data is driven.
- R5: A read returns the value present on `bus_ad_i` in the last cycle of the read strobe on `rsp_rdata`, valid while `req_ack` is high. The chip select stays low for exactly one cycle after the read strobe rises. The write-hold bit has no effect on reads.
- R6: When the turnaround bit (bit 4) is set, a read ends with one extra cycle in which all chip selects are high and the bus is undriven, before `req_ack`. The turnaround bit has no effect on writes.
- R7: When the write-hold bit (bit 5) is set, a write keeps its chip select low and its data driven for one cycle after the write strobe rises. When the bit is clear, the chip select is released in the cycle right after the strobe.
- R8: `req_be` bit 0 selects the low byte lane (`bus_ble_n`) and bit 1 selects the high lane (`bus_bhe_n`). The selected lanes are low, and the others high, for the whole time the chip select is low. Both lanes are high when no chip select is active.
- R9: Only the chip select numbered by `req_cs` goes low, and never more than one at a time. The cycle timing comes from that chip select's slot only.
- R10: `req_ack` is high for exactly one cycle, in the cycle after the last bus cycle. The total length is 2 + W + H + K cycles for a write (H = hold bit, K = write-hold bit) and 3 + W + H + T cycles for a read (T = turnaround bit). A request still held in the acknowledge cycle is not accepted until the following cycle.
- R11: During reset and right after it, all chip selects, strobes and lane enables are high, while `bus_ale`, `bus_ad_oe` and `req_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Global enable for bus cycles |
| cs_cfg | input | 24 | Four 6-bit timing slots, one per chip select |
| req_valid | input | 1 | Request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | 2 | Target chip-select number |
| req_addr | input | 17 | Halfword address |
| req_be | input | 2 | Byte-lane select (bit 1 high lane, bit 0 low lane) |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with `req_ack` |
| bus_ad_o | output | 16 | Multiplexed address/data out |
| bus_ad_i | input | 16 | Data in from the bus |
| bus_ad_oe | output | 1 | Output enable for `bus_ad_o` |
| bus_a_hi | output | 1 | Address bit 16 |
| bus_cs_n | output | 4 | Active-low chip selects |
| bus_ale | output | 1 | Address strobe for the external latch |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_bhe_n | output | 1 | Active-low high-byte enable |
| bus_ble_n | output | 1 | Active-low low-byte enable |

## Verification
The assertions rely on three properties of the inputs:
- the requester keeps `req_valid` and the request fields steady from the moment it raises them until `req_ack`;
- `req_cs` always names an existing chip select;
- a byte-lane selection is never empty.

The stimulus respects all three. Every request is applied on a falling edge, held until the acknowledge is observed, and then dropped. Timing slots are changed only while the controller is idle. Each vector uses a lane mask of 01, 10 or 11. Because the unselected slots are loaded with maximum timing values, a design that takes its timing from the wrong slot shows up as a length mismatch.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int WAIT_W = 3;
  localparam int CFG_W  = WAIT_W + 3;

  // Packed from MSB: bit5 write hold, bit4 turnaround, bit3 address hold, bits2:0 waits
  typedef struct packed {
    logic              whold;
    logic              turn;
    logic              ahold;
    logic [WAIT_W-1:0] waits;
  } cs_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_HOLD = 3'd2,
    ST_STRB = 3'd3,
    ST_TAIL = 3'd4,
    ST_TURN = 3'd5
  } seq_st_t;
endpackage

// File: rtl/xbus_cfg_mux.sv
module xbus_cfg_mux
  import xbus_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2
) (
  input  logic [NUM_CS*CFG_W-1:0] cs_cfg,
  input  logic [CS_W-1:0]         sel,
  output cs_cfg_t                 cfg_o
);
  cs_cfg_t slot [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
    assign slot[g] = cs_cfg[g*CFG_W +: CFG_W];
  end

  assign cfg_o = slot[sel];
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    bus_en,
  input  logic    req_valid,
  input  logic    req_write,
  input  cs_cfg_t sel_cfg,
  output seq_st_t st_q,
  output logic    write_q,
  output logic    load,
  output logic    capture,
  output logic    ack_q
);
  seq_st_t           st_n;
  logic [WAIT_W-1:0] wcnt_q, wcnt_n;
  logic              ahold_q, turn_q, whold_q;
  logic              done;

  always_comb begin
    st_n    = st_q;
    wcnt_n  = wcnt_q;
    done    = 1'b0;
    load    = 1'b0;
    capture = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid && bus_en && !ack_q) begin
          st_n   = ST_ADDR;
          wcnt_n = sel_cfg.waits;
          load   = 1'b1;
        end
      end
      ST_ADDR: begin
        if (wcnt_q != '0) wcnt_n = wcnt_q - 1'b1;
        else              st_n   = ahold_q ? ST_HOLD : ST_STRB;
      end
      ST_HOLD: st_n = ST_STRB;
      ST_STRB: begin
        if (write_q) begin
          if (whold_q) st_n = ST_TAIL;
          else begin
            st_n = ST_IDLE;
            done = 1'b1;
          end
        end else begin
          capture = 1'b1;
          st_n    = ST_TAIL;
        end
      end
      ST_TAIL: begin
        if (!write_q && turn_q) st_n = ST_TURN;
        else begin
          st_n = ST_IDLE;
          done = 1'b1;
        end
      end
      ST_TURN: begin
        st_n = ST_IDLE;
        done = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wcnt_q  <= '0;
      ack_q   <= 1'b0;
      write_q <= 1'b0;
      ahold_q <= 1'b0;
      turn_q  <= 1'b0;
      whold_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      wcnt_q <= wcnt_n;
      ack_q  <= done;
      if (load) begin
        write_q <= req_write;
        ahold_q <= sel_cfg.ahold;
        turn_q  <= sel_cfg.turn;
        whold_q <= sel_cfg.whold;
      end
    end
  end

  AST_OFF_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !bus_en) |=> (st_q == ST_IDLE)); // R1
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |=> !ack_q); // R10
  AST_ACK_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_q |-> (st_q == ST_IDLE)); // R10
  AST_WAIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADDR && wcnt_q == '0) |=> (st_q != ST_ADDR)); // R2
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  seq_st_t                  st,
  input  logic                     write_q,
  input  logic                     load,
  input  logic                     capture,
  input  logic [CS_W-1:0]          req_cs,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [1:0]               req_be,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W-1:0]        bus_ad_i,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [DATA_W-1:0]        bus_ad_o,
  output logic                     bus_ad_oe,
  output logic [ADDR_W-DATA_W-1:0] bus_a_hi,
  output logic [NUM_CS-1:0]        bus_cs_n,
  output logic                     bus_ale,
  output logic                     bus_rd_n,
  output logic                     bus_wr_n,
  output logic                     bus_bhe_n,
  output logic                     bus_ble_n
);
  logic [CS_W-1:0]   sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        be_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              active, addr_phase, strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      addr_q  <= '0;
      be_q    <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (load) begin
        sel_q   <= req_cs;
        addr_q  <= req_addr;
        be_q    <= req_be;
        wdata_q <= req_wdata;
      end
      if (capture) rdata_q <= bus_ad_i;
    end
  end

  always_comb begin
    active     = (st == ST_ADDR) || (st == ST_HOLD) || (st == ST_STRB) || (st == ST_TAIL);
    addr_phase = (st == ST_ADDR) || (st == ST_HOLD);
    strobe     = (st == ST_STRB);
    bus_ale    = (st == ST_ADDR);
    bus_rd_n   = !(strobe && !write_q);
    bus_wr_n   = !(strobe && write_q);
    bus_ad_oe  = addr_phase || (write_q && (strobe || (st == ST_TAIL)));
    bus_ad_o   = addr_phase ? addr_q[DATA_W-1:0] : wdata_q;
    bus_a_hi   = active ? addr_q[ADDR_W-1:DATA_W] : '0;
    bus_ble_n  = !(active && be_q[0]);
    bus_bhe_n  = !(active && be_q[1]);
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign bus_cs_n[g] = !(active && (sel_q == CS_W'(g)));
  end

  assign rsp_rdata = rdata_q;

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n)); // R9
  AST_READ_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_rd_n); // R4
  AST_ALE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> (bus_rd_n && bus_wr_n && bus_ad_oe)); // R2
  AST_CS_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> !(&bus_cs_n)); // R5
  AST_LANES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (&bus_cs_n) |-> (bus_bhe_n && bus_ble_n)); // R8
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 17,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_en,
  input  logic [NUM_CS*CFG_W-1:0]  cs_cfg,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [CS_W-1:0]          req_cs,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [1:0]               req_be,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     req_ack,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [DATA_W-1:0]        bus_ad_o,
  input  logic [DATA_W-1:0]        bus_ad_i,
  output logic                     bus_ad_oe,
  output logic [HI_W-1:0]          bus_a_hi,
  output logic [NUM_CS-1:0]        bus_cs_n,
  output logic                     bus_ale,
  output logic                     bus_rd_n,
  output logic                     bus_wr_n,
  output logic                     bus_bhe_n,
  output logic                     bus_ble_n
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  cs_cfg_t    sel_cfg;
  seq_st_t    st;
  logic       write_q, load, capture;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  xbus_cfg_mux #(.NUM_CS(NUM_CS), .CS_W(CS_W)) cfg_mux_i (
    .cs_cfg (cs_cfg),
    .sel    (req_cs),
    .cfg_o  (sel_cfg)
  );

  xbus_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_en    (bus_en),
    .req_valid (req_valid),
    .req_write (req_write),
    .sel_cfg   (sel_cfg),
    .st_q      (st),
    .write_q   (write_q),
    .load      (load),
    .capture   (capture),
    .ack_q     (req_ack)
  );

  xbus_pins #(.NUM_CS(NUM_CS), .CS_W(CS_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) pins_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .st        (st),
    .write_q   (write_q),
    .load      (load),
    .capture   (capture),
    .req_cs    (req_cs),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .req_wdata (req_wdata),
    .bus_ad_i  (bus_ad_i),
    .rsp_rdata (rsp_rdata),
    .bus_ad_o  (bus_ad_o),
    .bus_ad_oe (bus_ad_oe),
    .bus_a_hi  (bus_a_hi),
    .bus_cs_n  (bus_cs_n),
    .bus_ale   (bus_ale),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_bhe_n (bus_bhe_n),
    .bus_ble_n (bus_ble_n)
  );
endmodule

// File: tb/xbus_ctrl_tb_top.sv
module xbus_ctrl_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk;
  logic        rst_n;
  logic        bus_en;
  logic [23:0] cs_cfg;
  logic        req_valid, req_write;
  logic [1:0]  req_cs, req_be;
  logic [16:0] req_addr;
  logic [15:0] req_wdata;
  logic        req_ack;
  logic [15:0] rsp_rdata, bus_ad_o, bus_ad_i;
  logic        bus_ad_oe;
  logic [0:0]  bus_a_hi;
  logic [3:0]  bus_cs_n;
  logic        bus_ale, bus_rd_n, bus_wr_n, bus_bhe_n, bus_ble_n;
  logic [15:0] rd_pattern;

  int n_chk = 0;
  int n_fail = 0;

  // vector: wr, cs[1:0], be[1:0], waits[2:0], ahold, turn, whold, addr[16:0], data[15:0]
  localparam logic [43:0] VEC [8] = '{
    {1'b0, 2'd0, 2'b11, 3'd0, 1'b0, 1'b0, 1'b0, 17'h01234, 16'hA55A},
    {1'b1, 2'd1, 2'b11, 3'd2, 1'b0, 1'b0, 1'b0, 17'h1ABCD, 16'h1357},
    {1'b0, 2'd2, 2'b11, 3'd7, 1'b1, 1'b1, 1'b0, 17'h10F0F, 16'hC3C3},
    {1'b1, 2'd3, 2'b01, 3'd1, 1'b1, 1'b0, 1'b1, 17'h00055, 16'h00AA},
    {1'b1, 2'd0, 2'b10, 3'd0, 1'b0, 1'b0, 1'b1, 17'h0FFFF, 16'hBB00},
    {1'b0, 2'd1, 2'b01, 3'd3, 1'b0, 1'b1, 1'b0, 17'h1FFFF, 16'h0077},
    {1'b1, 2'd2, 2'b11, 3'd0, 1'b1, 1'b1, 1'b0, 17'h00000, 16'hFFFF},
    {1'b0, 2'd3, 2'b10, 3'd5, 1'b1, 1'b0, 1'b1, 17'h12468, 16'h8001}
  };

  xbus_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .cs_cfg(cs_cfg),
    .req_valid(req_valid), .req_write(req_write), .req_cs(req_cs),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata), .bus_ad_o(bus_ad_o),
    .bus_ad_i(bus_ad_i), .bus_ad_oe(bus_ad_oe), .bus_a_hi(bus_a_hi),
    .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_bhe_n(bus_bhe_n), .bus_ble_n(bus_ble_n)
  );

  // external device model: drives read data only while the read strobe is low
  assign bus_ad_i = bus_rd_n ? 16'hDEAD : rd_pattern;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_outputs(input string req);
    chk(bus_cs_n == 4'hF && !bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe &&
        !req_ack && bus_bhe_n && bus_ble_n, req,
        {bus_cs_n, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, req_ack, bus_bhe_n, bus_ble_n},
        {4'hF, 7'b0110011});
  endtask

  task automatic run_cycle(input logic [43:0] v);
    logic        wr    = v[43];
    logic [1:0]  cs    = v[42:41];
    logic [1:0]  be    = v[40:39];
    logic [2:0]  w     = v[38:36];
    logic        ah    = v[35];
    logic        ta    = v[34];
    logic        wh    = v[33];
    logic [16:0] addr  = v[32:16];
    logic [15:0] data  = v[15:0];
    int obs = 0, ale_c = 0, hold_c = 0, strb_c = 0, tail_c = 0, idle_c = 0;
    int exp_len;
    bit strobe_seen = 0, addr_bad = 0, hold_bad = 0, strb_bad = 0, tail_bad = 0;
    bit cs_bad = 0, lane_bad = 0;
    logic cs_low;
    @(negedge clk);
    cs_cfg = '1;
    cs_cfg[cs*6 +: 6] = {wh, ta, ah, w};
    req_write = wr; req_cs = cs; req_be = be; req_addr = addr; req_wdata = data;
    rd_pattern = data;
    req_valid = 1'b1;
    while (obs < 64) begin
      @(negedge clk);
      if (req_ack) break;
      obs++;
      cs_low = (bus_cs_n != 4'hF);
      if (cs_low) begin
        if (bus_cs_n != ~(4'b0001 << cs)) cs_bad = 1;
        if ({~bus_bhe_n, ~bus_ble_n} != be) lane_bad = 1;
      end else idle_c++;
      if (bus_ale) begin
        ale_c++;
        if (!bus_ad_oe || bus_ad_o != addr[15:0] || bus_a_hi[0] != addr[16]) addr_bad = 1;
      end else if (cs_low && bus_rd_n && bus_wr_n && !strobe_seen) begin
        hold_c++;
        if (!bus_ad_oe || bus_ad_o != addr[15:0] || bus_a_hi[0] != addr[16]) hold_bad = 1;
      end
      if (!bus_rd_n || !bus_wr_n) begin
        strb_c++;
        strobe_seen = 1;
        if (wr) begin
          if (bus_wr_n || !bus_rd_n || !bus_ad_oe || bus_ad_o != data) strb_bad = 1;
        end else begin
          if (bus_rd_n || !bus_wr_n || bus_ad_oe) strb_bad = 1;
        end
      end else if (strobe_seen && cs_low) begin
        tail_c++;
        if (wr && (!bus_ad_oe || bus_ad_o != data)) tail_bad = 1;
        if (!wr && bus_ad_oe) tail_bad = 1;
      end
    end
    exp_len = wr ? (2 + w + ah + wh) : (3 + w + ah + ta);
    chk(obs == exp_len, "R10 cycle length", obs, exp_len);
    chk(ale_c == 1 + w, "R2 address phase cycles", ale_c, 1 + w);
    chk(!addr_bad, "R2 address value in address phase", addr_bad, 0);
    chk(hold_c == ah && !hold_bad, "R3 address hold cycle", hold_c, ah);
    chk(strb_c == 1 && !strb_bad, "R4 strobe cycle", strb_c, 1);
    if (wr) chk(tail_c == wh && !tail_bad, "R7 write hold", tail_c, wh);
    else    chk(tail_c == 1 && !tail_bad, "R5 chip select after read strobe", tail_c, 1);
    chk(idle_c == (wr ? 0 : ta), "R6 turnaround cycle", idle_c, wr ? 0 : ta);
    chk(!cs_bad, "R9 selected chip select", cs_bad, 0);
    chk(!lane_bad, "R8 lane enables", lane_bad, 0);
    if (!wr) chk(rsp_rdata == data, "R5 read data", rsp_rdata, data);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ack && bus_cs_n == 4'hF, "R10 ack single pulse",
        {req_ack, bus_cs_n}, {1'b0, 4'hF});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=hung expected=complete");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt_cs, cnt_ack, obs;
    rst_n = 1'b0; bus_en = 1'b1; cs_cfg = '0; req_valid = 1'b0; req_write = 1'b0;
    req_cs = '0; req_be = 2'b11; req_addr = '0; req_wdata = '0; rd_pattern = '0;
    repeat (3) @(negedge clk);
    idle_outputs("R11 outputs during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_outputs("R11 outputs after reset");

    // table of vectors
    for (int i = 0; i < 8; i++) run_cycle(VEC[i]);

    // R1: disabled controller ignores a pending request
    @(negedge clk);
    bus_en = 1'b0; cs_cfg = '0;
    req_write = 1'b0; req_cs = 2'd1; req_be = 2'b11; req_addr = 17'h00321;
    rd_pattern = 16'h4242; req_valid = 1'b1;
    cnt_cs = 0; cnt_ack = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (bus_cs_n != 4'hF) cnt_cs++;
      if (req_ack) cnt_ack++;
    end
    chk(cnt_cs == 0, "R1 no chip select while disabled", cnt_cs, 0);
    chk(cnt_ack == 0, "R1 no ack while disabled", cnt_ack, 0);
    bus_en = 1'b1;
    obs = 0;
    while (obs < 64) begin
      @(negedge clk);
      if (req_ack) break;
      obs++;
    end
    chk(obs == 3, "R1 request runs after enable", obs, 3);
    chk(rsp_rdata == 16'h4242, "R1 read data after enable", rsp_rdata, 16'h4242);

    // R10: request still held during the ack cycle is not accepted there
    @(negedge clk);
    chk(bus_cs_n == 4'hF, "R10 no accept in ack cycle", bus_cs_n, 4'hF);
    @(negedge clk);
    chk(bus_cs_n == 4'b1101 && bus_ale, "R10 accept after ack cycle",
        {bus_cs_n, bus_ale}, {4'b1101, 1'b1});
    req_valid = 1'b0;
    obs = 1;
    while (obs < 64) begin
      @(negedge clk);
      if (req_ack) break;
      obs++;
    end
    chk(obs == 3, "R10 second request length", obs, 3);
    @(negedge clk);
    idle_outputs("R11 idle after last request");

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule